// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog. It holds a 32-bit down-counter that runs from a programmable start value. When the count first runs out, the block raises an interrupt flag and restarts the count from the same value. If the count runs out a second time while the flag has still not been cleared, and the reset function is enabled, the block asserts a system reset output. Software keeps the system alive by clearing the interrupt or by rewriting the start value, and either action restarts the count at once.

All registers are reached through a single-cycle register port: an address, write data, a write strobe and a read strobe. Read data is combinational from the address while the read strobe is high. A lock register guards every other write. Writing the 32-bit key 0x1ACCE551 opens the other registers to writes, and writing any other value closes them again. Reads are allowed at all times.

Top module: `twostage_watchdog`

## Requirements
- R1: After reset the block is locked (offset 0xC00 reads 1). The start value at 0x000 and the count at 0x004 both read 0xFFFFFFFF, control at 0x008 reads 0, and `irq_o` and `sysrst_o` are low.
- R2: A write of 0x1ACCE551 to offset 0xC00 unlocks the block, and a write of any other value locks it. The lock register accepts writes in either state.
- R3: While the block is locked, writes to 0x000, 0x008 and 0x00C have no effect. Reads of every offset still return current contents.
- R4: An unlocked write to 0x000 stores the data as the start value, with 0 stored as 1. At the same clock edge the count is loaded with the stored value.
- R5: While control bit 0 is 1, the count falls by one per clock. At the edge after it reaches 0, the interrupt flag is set and the count is reloaded. The first interrupt therefore comes L+1 cycles after the count is loaded with L. While control bit 0 is 0, the count holds.
- R6: When the count runs out while the flag is set and control bit 1 is 1, `sysrst_o` rises at that edge, which is 2L+2 cycles after loading. If control bit 1 is 0, the count only reloads and `sysrst_o` stays low.
- R7: An unlocked write of any value to 0x00C clears the interrupt flag and reloads the count from the start value. This write is the keep-alive.
- R8: Bit 0 of 0x010 is the raw flag. Bit 0 of 0x014 is the raw flag ANDed with control bit 0, and `irq_o` follows it. Control reads back at 0x008 bits [1:0].
- R9: With the default hold option, `sysrst_o` stays high until an unlocked write to 0x00C or a block reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_addr | input | ADDR_W (12) | Register byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, valid while `bus_rd` is high |
| irq_o | output | 1 | Masked interrupt |
| sysrst_o | output | 1 | System reset request |

## Verification
A table of start values and control settings runs the countdown. The table contains full operation (interrupt and reset enabled), interrupt only, counting stopped, the smallest start value, and a zero write that must be clamped. Together these cases separate the first expiry from the second, show that reset depends on control bit 1, and expose off-by-one errors in the L+1 and 2L+2 cycle timing. Directed sequences then try writes while locked, a keep-alive clear part-way through a count, a clear between the two expiries, and disabling the block while the flag is pending. These separate the raw flag from the masked flag and show how long the reset output is held.

// File: rtl/wd2_pkg.sv
package wd2_pkg;

   localparam int unsigned OFS_LOAD  = 32'h000;
   localparam int unsigned OFS_VALUE = 32'h004;
   localparam int unsigned OFS_CTRL  = 32'h008;
   localparam int unsigned OFS_ICLR  = 32'h00C;
   localparam int unsigned OFS_RAW   = 32'h010;
   localparam int unsigned OFS_MSK   = 32'h014;
   localparam int unsigned OFS_LOCK  = 32'hC00;

   localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;
   localparam int unsigned CTRL_W     = 2;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_LOAD,
      SEL_VALUE,
      SEL_CTRL,
      SEL_ICLR,
      SEL_RAW,
      SEL_MSK,
      SEL_LOCK
   } reg_sel_e;

endpackage

// File: rtl/wd2_regs.sv
module wd2_regs
   import wd2_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter logic [31:0] LOAD_RST = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] cnt_i,
   input  logic              flag_i,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] load_q,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              locked_q,
   output logic              reload_o,
   output logic [DATA_W-1:0] reload_val_o,
   output logic              clear_o
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   if (DATA_W != 32) begin : g_bad_width
      $error("wd2_regs: DATA_W must be 32 to match the unlock key");
   end
   if (ADDR_W < 12 || ADDR_W > 32) begin : g_bad_addr
      $error("wd2_regs: ADDR_W must lie in 12..32");
   end

   reg_sel_e          sel;
   logic              wr_ok;
   logic              load_wr;
   logic              ctrl_wr;
   logic [DATA_W-1:0] load_new;

   always_comb begin
      if      (addr == ADDR_W'(OFS_LOAD))  sel = SEL_LOAD;
      else if (addr == ADDR_W'(OFS_VALUE)) sel = SEL_VALUE;
      else if (addr == ADDR_W'(OFS_CTRL))  sel = SEL_CTRL;
      else if (addr == ADDR_W'(OFS_ICLR))  sel = SEL_ICLR;
      else if (addr == ADDR_W'(OFS_RAW))   sel = SEL_RAW;
      else if (addr == ADDR_W'(OFS_MSK))   sel = SEL_MSK;
      else if (addr == ADDR_W'(OFS_LOCK))  sel = SEL_LOCK;
      else                                 sel = SEL_NONE;
   end

   assign wr_ok    = wr && !locked_q;
   assign load_wr  = wr_ok && (sel == SEL_LOAD);
   assign ctrl_wr  = wr_ok && (sel == SEL_CTRL);
   assign clear_o  = wr_ok && (sel == SEL_ICLR);
   assign load_new = (wdata == '0) ? ONE : wdata;

   assign reload_o     = load_wr || clear_o;
   assign reload_val_o = load_wr ? load_new : load_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b1;
         load_q   <= DATA_W'(LOAD_RST);
         ctrl_q   <= '0;
      end else begin
         if (wr && (sel == SEL_LOCK)) locked_q <= (wdata != DATA_W'(UNLOCK_KEY));
         if (load_wr)                 load_q   <= load_new;
         if (ctrl_wr)                 ctrl_q   <= wdata[CTRL_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         unique case (sel)
            SEL_LOAD:  rdata = load_q;
            SEL_VALUE: rdata = cnt_i;
            SEL_CTRL:  rdata = DATA_W'(ctrl_q);
            SEL_RAW:   rdata = DATA_W'(flag_i);
            SEL_MSK:   rdata = DATA_W'(flag_i && ctrl_q[0]);
            SEL_LOCK:  rdata = DATA_W'(locked_q);
            default:   rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/wd2_counter.sv
module wd2_counter #(
   parameter int unsigned DATA_W   = 32,
   parameter logic [31:0] LOAD_RST = 32'hFFFF_FFFF,
   parameter bit          RST_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              rst_en,
   input  logic              reload,
   input  logic [DATA_W-1:0] reload_val,
   input  logic              clear,
   output logic [DATA_W-1:0] cnt_q,
   output logic              flag_q,
   output logic              sysrst_q
);

   logic expire;
   logic second;

   assign expire = run_en && !reload && (cnt_q == '0);
   assign second = expire && flag_q && rst_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= DATA_W'(LOAD_RST);
      end else if (reload || expire) begin
         cnt_q <= reload_val;
      end else if (run_en) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (clear)  flag_q <= 1'b0;
      else if (expire) flag_q <= 1'b1;
   end

   if (RST_HOLD) begin : g_rst_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      sysrst_q <= 1'b0;
         else if (clear)  sysrst_q <= 1'b0;
         else if (second) sysrst_q <= 1'b1;
      end
   end else begin : g_rst_pulse
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sysrst_q <= 1'b0;
         else        sysrst_q <= second;
      end
   end

endmodule

// File: rtl/twostage_watchdog.sv
module twostage_watchdog
   import wd2_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter logic [31:0] LOAD_RST = 32'hFFFF_FFFF,
   parameter bit          RST_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              sysrst_o
);

   logic [DATA_W-1:0] load_w;
   logic [CTRL_W-1:0] ctrl_w;
   logic              locked_w;
   logic              reload_w;
   logic [DATA_W-1:0] reload_val_w;
   logic              clear_w;
   logic [DATA_W-1:0] cnt_w;
   logic              flag_w;

   wd2_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .LOAD_RST (LOAD_RST)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr         (bus_addr),
      .wdata        (bus_wdata),
      .wr           (bus_wr),
      .rd           (bus_rd),
      .cnt_i        (cnt_w),
      .flag_i       (flag_w),
      .rdata        (bus_rdata),
      .load_q       (load_w),
      .ctrl_q       (ctrl_w),
      .locked_q     (locked_w),
      .reload_o     (reload_w),
      .reload_val_o (reload_val_w),
      .clear_o      (clear_w)
   );

   wd2_counter #(
      .DATA_W   (DATA_W),
      .LOAD_RST (LOAD_RST),
      .RST_HOLD (RST_HOLD)
   ) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (ctrl_w[0]),
      .rst_en     (ctrl_w[1]),
      .reload     (reload_w),
      .reload_val (reload_val_w),
      .clear      (clear_w),
      .cnt_q      (cnt_w),
      .flag_q     (flag_w),
      .sysrst_q   (sysrst_o)
   );

   assign irq_o = flag_w && ctrl_w[0];

endmodule

// File: rtl/wd2_checker.sv
module wd2_checker
   import wd2_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              wr,
   input logic              locked,
   input logic [DATA_W-1:0] load_q,
   input logic [CTRL_W-1:0] ctrl_q,
   input logic [DATA_W-1:0] cnt_q,
   input logic              flag_q,
   input logic              sysrst,
   input logic              reload
);

   // R5: running count falls by exactly one
   a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[0] && !reload && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R5: stopped count holds
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[0] && !reload) |=> $stable(cnt_q));

   // R3: start value cannot change while locked
   a_r3_locked_load: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(load_q));

   // R2: key write opens the block
   a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == ADDR_W'(OFS_LOCK) && wdata == DATA_W'(UNLOCK_KEY)) |=> !locked);

   // R7: unlocked clear drops the flag
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !locked && addr == ADDR_W'(OFS_ICLR)) |=> !flag_q);

   // R6: reset rises only with a pending flag and reset enabled
   a_r6_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sysrst) |-> ($past(flag_q) && $past(ctrl_q[1])));

endmodule

bind twostage_watchdog wd2_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_wd2_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .addr   (bus_addr),
   .wdata  (bus_wdata),
   .wr     (bus_wr),
   .locked (locked_w),
   .load_q (load_w),
   .ctrl_q (ctrl_w),
   .cnt_q  (cnt_w),
   .flag_q (flag_w),
   .sysrst (sysrst_o),
   .reload (reload_w)
);

// File: tb/twostage_watchdog_bench.sv
`timescale 1ns/1ps
module twostage_watchdog_bench;

   localparam int AW = 12;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [DW-1:0] bus_rdata;
   logic          irq_o;
   logic          sysrst_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   twostage_watchdog u_twostage_watchdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o),
      .sysrst_o  (sysrst_o)
   );

   localparam logic [AW-1:0] A_LOAD = 12'h000, A_VAL = 12'h004, A_CTRL = 12'h008,
                             A_ICLR = 12'h00C, A_RAW = 12'h010, A_MSK = 12'h014,
                             A_LOCK = 12'hC00;
   localparam logic [31:0]   KEY = 32'h1ACCE551;

   typedef struct packed {
      logic [31:0] load;
      logic [1:0]  ctrl;
      logic [7:0]  per;
      logic        exp_flag;
      logic [31:0] exp_cnt;
      logic        exp_rst;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VECS [NV] = '{
      '{32'd3, 2'd3, 8'd3, 1'b1, 32'd3, 1'b1},
      '{32'd4, 2'd1, 8'd4, 1'b1, 32'd4, 1'b0},
      '{32'd2, 2'd0, 8'd2, 1'b0, 32'd2, 1'b0},
      '{32'd1, 2'd3, 8'd1, 1'b1, 32'd1, 1'b1},
      '{32'd0, 2'd3, 8'd1, 1'b1, 32'd1, 1'b1}
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      bus_addr = a;
      bus_rd   = 1'b1;
      #1;
      d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      rd(A_LOCK, d); check("R1", "lock", d, 32'd1);
      rd(A_LOAD, d); check("R1", "load", d, 32'hFFFFFFFF);
      rd(A_VAL,  d); check("R1", "value", d, 32'hFFFFFFFF);
      rd(A_CTRL, d); check("R1", "ctrl", d, 32'd0);
      check("R1", "irq", {31'd0, irq_o}, 32'd0);
      check("R1", "sysrst", {31'd0, sysrst_o}, 32'd0);

      // R3 locked writes ignored
      wr(A_LOAD, 32'd7);
      rd(A_LOAD, d); check("R3", "load while locked", d, 32'hFFFFFFFF);
      wr(A_CTRL, 32'd3);
      rd(A_CTRL, d); check("R3", "ctrl while locked", d, 32'd0);

      // R2 lock / unlock
      wr(A_LOCK, KEY);
      rd(A_LOCK, d); check("R2", "unlocked", d, 32'd0);
      wr(A_LOCK, 32'd1);
      rd(A_LOCK, d); check("R2", "relocked", d, 32'd1);
      wr(A_LOCK, KEY);

      // R4 R5 R6 table of periods
      for (int i = 0; i < NV; i++) begin
         wr(A_CTRL, 32'd0);
         wr(A_ICLR, 32'd0);
         wr(A_LOAD, VECS[i].load);
         rd(A_VAL, d); check("R4", "value after load", d, VECS[i].exp_cnt);
         wr(A_CTRL, {30'd0, VECS[i].ctrl});
         tick(int'(VECS[i].per));
         rd(A_RAW, d); check("R5", "flag before expiry", d, 32'd0);
         tick(1);
         rd(A_RAW, d); check("R5", "flag at first expiry", d, {31'd0, VECS[i].exp_flag});
         rd(A_VAL, d); check("R5", "value at first expiry", d, VECS[i].exp_cnt);
         tick(int'(VECS[i].per));
         check("R6", "sysrst before second expiry", {31'd0, sysrst_o}, 32'd0);
         tick(1);
         check("R6", "sysrst at second expiry", {31'd0, sysrst_o}, {31'd0, VECS[i].exp_rst});
      end

      // R8 masked status
      wr(A_CTRL, 32'd0);
      wr(A_ICLR, 32'd0);
      wr(A_LOAD, 32'd3);
      wr(A_CTRL, 32'd1);
      tick(4);
      rd(A_MSK, d); check("R8", "masked set", d, 32'd1);
      check("R8", "irq set", {31'd0, irq_o}, 32'd1);
      rd(A_CTRL, d); check("R8", "ctrl readback", d, 32'd1);
      wr(A_CTRL, 32'd0);
      rd(A_RAW, d); check("R8", "raw kept", d, 32'd1);
      rd(A_MSK, d); check("R8", "masked off", d, 32'd0);
      check("R8", "irq off", {31'd0, irq_o}, 32'd0);

      // R7 keep-alive
      wr(A_ICLR, 32'd0);
      wr(A_LOAD, 32'd6);
      wr(A_CTRL, 32'd1);
      tick(4);
      rd(A_VAL, d); check("R5", "value mid count", d, 32'd2);
      wr(A_ICLR, 32'd0);
      rd(A_VAL, d); check("R7", "reload on clear", d, 32'd6);
      tick(6);
      check("R7", "no irq after keepalive", {31'd0, irq_o}, 32'd0);
      tick(1);
      check("R7", "irq after full period", {31'd0, irq_o}, 32'd1);

      // R7 R6 R9 clear between expiries, hold
      wr(A_CTRL, 32'd3);
      wr(A_ICLR, 32'd0);
      rd(A_RAW, d); check("R7", "flag cleared", d, 32'd0);
      tick(7);
      rd(A_RAW, d); check("R7", "flag after restart", d, 32'd1);
      check("R6", "no reset after cleared flag", {31'd0, sysrst_o}, 32'd0);
      tick(7);
      check("R6", "reset on second expiry", {31'd0, sysrst_o}, 32'd1);
      tick(3);
      check("R9", "reset held", {31'd0, sysrst_o}, 32'd1);
      wr(A_ICLR, 32'd0);
      check("R9", "reset released by clear", {31'd0, sysrst_o}, 32'd0);

      // R3 locked clear ignored
      wr(A_LOCK, 32'd0);
      tick(6);
      rd(A_RAW, d); check("R5", "flag set while locked", d, 32'd1);
      wr(A_ICLR, 32'd0);
      rd(A_RAW, d); check("R3", "clear while locked", d, 32'd1);

      // R1 block reset mid-run
      rst_n = 1'b0;
      tick(1);
      rst_n = 1'b1;
      rd(A_LOCK, d); check("R1", "lock after reset", d, 32'd1);
      rd(A_RAW, d);  check("R1", "flag after reset", d, 32'd0);
      check("R1", "sysrst after reset", {31'd0, sysrst_o}, 32'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule